// File: doc/BRIEF.md
# Segmented Memory Mapping Register File

This block holds the page-translation entries of a memory management unit behind an 8-bit I/O port. A 64-entry table of 6-bit physical page numbers is split into four segments of sixteen entries each. Sixteen consecutive I/O offsets give a window onto the segment that a select register currently names. Software changes segments by writing that register and then reads or rewrites the sixteen visible entries.

A control register carries three flags: translation enable, window enable and a boot-RAM flag. A further register holds an 8-bit window offset. All three are exported to the surrounding address logic. A translation port takes a 4-bit logical bank and returns its physical page. With translation enabled, the page is the entry for that bank in the current segment. With translation disabled, the page is a fixed pass-through value.

Writes take effect on the clock edge. Read data is combinational from the current state, so a read returns its value in the same cycle that the address is presented.

Top module: `segmap_regfile`

## Requirements
- R1: After reset, every table entry is 0, the segment is 0, the window offset is 0, and all three flags are 0. A read of the control offset 0x93 therefore returns 0x3E.
- R2: A write with cs=1 and we=1 to offset 0x80+i (i = 0..15) stores wdata[5:0] at table index i + 16*segment. wdata[7:6] is dropped.
- R3: A read of offset 0x80+i returns {2'b00, entry[i + 16*segment]}. Entries in the other segments are not affected by the write.
- R4: A write to offset 0x90 sets the segment to wdata[1:0]. wdata[7:2] is ignored, so writing 0xFD selects segment 1.
- R5: A write to offset 0x92 stores all 8 bits of wdata. The stored value appears on win_ofs after the clock edge.
- R6: A write to offset 0x93 sets boot_ram from bit 0, win_en from bit 6 and mmu_en from bit 7. All other bits are ignored.
- R7: A read of offset 0x93 returns 0x3E OR (mmu_en<<7) OR (win_en<<6) OR boot_ram.
- R8: While mmu_en=1, xlat_page equals the table entry at index xlat_bank + 16*segment. While mmu_en=0, xlat_page equals PASS_BASE (default 0x30) OR xlat_bank.
- R9: Any offset other than 0x80..0x8F and 0x93 reads as 0xFF. This includes the write-only offsets 0x90 and 0x92. Writes to offsets outside 0x80..0x8F, 0x90, 0x92 and 0x93 change no state.
- R10: A cycle without both cs and we high changes no state. A write is visible at the outputs right after its clock edge, and reads need no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable, qualified by cs |
| addr | input | 8 | I/O offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| xlat_bank | input | 4 | Logical bank to translate |
| xlat_page | output | 6 | Translated physical page |
| mmu_en | output | 1 | Translation enable flag |
| win_en | output | 1 | Window enable flag |
| boot_ram | output | 1 | Boot-RAM flag |
| win_ofs | output | 8 | Window offset |

## Verification
A wrong segment value or a wrong entry index shows up on the first entry read after it, and on xlat_page as soon as translation is enabled. The bench therefore fills every entry of all four segments with distinct values and reads each one back through both paths. A control flag that is lost or misplaced shows on its output pin one cycle after the write, and on the same-cycle readback of 0x93. A decode that is too wide is caught by writes to unmapped offsets followed by full readback of the table and the flags.

// File: rtl/segmap_regfile.sv
module segmap_regfile #(
  parameter int SEG_BITS  = 2,
  parameter int BANK_BITS = 4,
  parameter int PAGE_W    = 6,
  parameter logic [PAGE_W-1:0] PASS_BASE = 6'h30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 we,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [BANK_BITS-1:0] xlat_bank,
  output logic [PAGE_W-1:0]    xlat_page,
  output logic                 mmu_en,
  output logic                 win_en,
  output logic                 boot_ram,
  output logic [7:0]           win_ofs
);
  localparam int DEPTH = 1 << (SEG_BITS + BANK_BITS);
  localparam logic [7:0] ENT_BASE = 8'h80;
  localparam logic [7:0] SEG_ADR  = 8'h90;
  localparam logic [7:0] WIN_ADR  = 8'h92;
  localparam logic [7:0] CTL_ADR  = 8'h93;
  localparam logic [7:0] CTL_FILL = 8'h3E;

  logic [PAGE_W-1:0]   tbl [DEPTH];
  logic [SEG_BITS-1:0] seg;

  wire wr     = cs && we;
  wire hit_e  = (addr[7:BANK_BITS] == ENT_BASE[7:BANK_BITS]);
  wire [SEG_BITS+BANK_BITS-1:0] widx = {seg, addr[BANK_BITS-1:0]};
  wire [SEG_BITS+BANK_BITS-1:0] xidx = {seg, xlat_bank};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      seg      <= '0;
      win_ofs  <= '0;
      mmu_en   <= 1'b0;
      win_en   <= 1'b0;
      boot_ram <= 1'b0;
    end else if (wr) begin
      if (hit_e) tbl[widx] <= wdata[PAGE_W-1:0];
      if (addr == SEG_ADR) seg <= wdata[SEG_BITS-1:0];
      if (addr == WIN_ADR) win_ofs <= wdata;
      if (addr == CTL_ADR) begin
        mmu_en   <= wdata[7];
        win_en   <= wdata[6];
        boot_ram <= wdata[0];
      end
    end
  end

  always_comb begin
    rdata = 8'hFF;
    if (hit_e)
      rdata = {{(8-PAGE_W){1'b0}}, tbl[widx]};
    else if (addr == CTL_ADR)
      rdata = CTL_FILL | {mmu_en, win_en, 5'b0, boot_ram};
  end

  assign xlat_page = mmu_en ? tbl[xidx] : (PASS_BASE | PAGE_W'(xlat_bank));

  // R6
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTL_ADR) |=> {mmu_en, win_en, boot_ram} == {$past(wdata[7]), $past(wdata[6]), $past(wdata[0])});
  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == CTL_ADR) |=> $stable({mmu_en, win_en, boot_ram}));
  // R5
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == WIN_ADR) |=> win_ofs == $past(wdata));
  // R7
  ctl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTL_ADR) |-> (rdata[5:1] == 5'h1F && rdata[7] == mmu_en && rdata[0] == boot_ram));
  // R3
  ent_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_e |-> rdata[7:6] == 2'b00);
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_e && addr != CTL_ADR) |-> rdata == 8'hFF);
endmodule

// File: tb/segmap_regfile_test.sv
module segmap_regfile_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cs = 0, we = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] xlat_bank = 4'h0;
  logic [5:0] xlat_page;
  logic mmu_en, win_en, boot_ram;
  logic [7:0] win_ofs;

  int checks = 0, errors = 0;
  logic [5:0] model [64];

  segmap_regfile uut (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .xlat_bank(xlat_bank), .xlat_page(xlat_page),
    .mmu_en(mmu_en), .win_en(win_en), .boot_ram(boot_ram), .win_ofs(win_ofs));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic c = 1, input logic w = 1);
    @(negedge clk);
    cs = c; we = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; we = 0; addr = a;
    #1 d = rdata;
    cs = 0;
  endtask

  task automatic check_all_entries(input string req);
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      wr(8'h90, 8'(s));
      for (int i = 0; i < 16; i++) begin
        rd(8'h80 + 8'(i), d);
        chk(req, d, {2'b00, model[s*16+i]});
      end
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(8'h93, d);
    chk("R1 ctrl read", d, 8'h3E);
    chk("R1 flags", {mmu_en, win_en, boot_ram}, 3'b000);
    chk("R1 win_ofs", win_ofs, 8'h00);
    for (int i = 0; i < 16; i++) begin
      rd(8'h80 + 8'(i), d);
      chk("R1 entry seg0", d, 8'h00);
    end
    check_all_entries("R1 entries");
  endtask

  task automatic t_entries;
    for (int s = 0; s < 4; s++) begin
      wr(8'h90, 8'(s));
      for (int i = 0; i < 16; i++) begin
        logic [7:0] v;
        v = 8'((s*16+i) * 7) ^ 8'hC5;
        wr(8'h80 + 8'(i), v);
        model[s*16+i] = v[5:0];
      end
    end
    check_all_entries("R2/R3 entry readback");
  endtask

  task automatic t_segment;
    logic [7:0] d;
    wr(8'h90, 8'hFD);
    rd(8'h83, d);
    chk("R4 segment low bits", d, {2'b00, model[16+3]});
    wr(8'h90, 8'hFE);
    rd(8'h8F, d);
    chk("R4 segment 2", d, {2'b00, model[32+15]});
  endtask

  task automatic t_window;
    wr(8'h92, 8'hA7);
    chk("R5 win_ofs", win_ofs, 8'hA7);
    wr(8'h92, 8'h5A);
    chk("R5 win_ofs second", win_ofs, 8'h5A);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(8'h93, 8'h41);
    chk("R6 flags 0x41", {mmu_en, win_en, boot_ram}, 3'b011);
    rd(8'h93, d);
    chk("R7 read 0x41", d, 8'h7F);
    wr(8'h93, 8'h3E);
    chk("R6 other bits ignored", {mmu_en, win_en, boot_ram}, 3'b000);
    wr(8'h93, 8'h80);
    rd(8'h93, d);
    chk("R7 read mmu only", d, 8'hBE);
    wr(8'h93, 8'hFF);
    rd(8'h93, d);
    chk("R7 read all", d, 8'hFF);
    wr(8'h93, 8'h00);
    rd(8'h93, d);
    chk("R7 read none", d, 8'h3E);
  endtask

  task automatic t_xlat;
    wr(8'h93, 8'h00);
    for (int b = 0; b < 16; b++) begin
      @(negedge clk); xlat_bank = 4'(b); #1;
      chk("R8 pass-through", xlat_page, 6'h30 | 6'(b));
    end
    wr(8'h93, 8'h80);
    for (int s = 0; s < 4; s++) begin
      wr(8'h90, 8'(s));
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); xlat_bank = 4'(b); #1;
        chk("R8 translated", xlat_page, model[s*16+b]);
      end
    end
    wr(8'h93, 8'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    logic [7:0] lst [7] = '{8'h00, 8'h7F, 8'h90, 8'h91, 8'h92, 8'h94, 8'hFF};
    foreach (lst[k]) begin
      rd(lst[k], d);
      chk("R9 unmapped read", d, 8'hFF);
    end
    wr(8'h94, 8'hC1);
    wr(8'h7F, 8'hC1);
    wr(8'hA3, 8'h15);
    wr(8'h00, 8'h2A);
    chk("R9 flags after stray writes", {mmu_en, win_en, boot_ram}, 3'b000);
    chk("R9 win_ofs after stray writes", win_ofs, 8'h5A);
    check_all_entries("R9 entries after stray writes");
  endtask

  task automatic t_qualify;
    logic [7:0] d;
    wr(8'h90, 8'h00);
    wr(8'h85, 8'h3F, 1'b0, 1'b1);
    wr(8'h85, 8'h3F, 1'b1, 1'b0);
    wr(8'h93, 8'hC1, 1'b0, 1'b1);
    wr(8'h92, 8'h11, 1'b1, 1'b0);
    rd(8'h85, d);
    chk("R10 entry not written", d, {2'b00, model[5]});
    chk("R10 flags not written", {mmu_en, win_en, boot_ram}, 3'b000);
    chk("R10 win_ofs not written", win_ofs, 8'h5A);
    @(negedge clk); cs = 1; we = 1; addr = 8'h85; wdata = 8'h2B;
    #1 chk("R10 comb read before edge", rdata, {2'b00, model[5]});
    @(posedge clk); #1;
    chk("R10 visible after edge", rdata, 8'h2B);
    model[5] = 6'h2B;
    @(negedge clk); cs = 0; we = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_entries;
    t_segment;
    t_window;
    t_ctrl;
    t_xlat;
    t_unmapped;
    t_qualify;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule